// File: doc/BRIEF.md
# System Control Register Block

This block keeps the privileged control state of a small processor core: the TLB pointer and wired count, the translation tag with its address-space identifier, the processor status word, the exception cause word, the two exception return addresses, the exception vector base and the user hardware-register enable mask. The pipeline writes and reads these through a single write port and a single read port, each choosing its register with a 5-bit selector. Reads are combinational. Writes take effect at the next rising clock edge.

Besides plain access, the block handles the control instructions that act on this state. Exception return chooses its target address from the error or the normal return register and drops the matching level flag. Interrupt disable and enable hand back the Status word as it was and then change the global enable bit. User hardware-register reads are allowed only when the matching enable bit is set. Floating-point operations are checked against the coprocessor-1 usable bit. Faults come out as an exception request with a cause code. The block also gives a one-cycle flush request for the translation cache and a re-evaluation hint for the interrupt logic.

Selector map: 0 Index, 1 Wired, 2 HWREna, 3 EntryHi, 4 Status, 5 Cause, 6 EPC, 7 ErrorEPC, 8 EBase. Every other selector is unimplemented. Status bit positions: IE=0, EXL=1, ERL=2, UM=4, CU1=29.

Top module: `cp0_regs`

## Requirements
- R1: A Status write stores the written bits under mask 0xFA78FF01. Written bits 4, 2 and 1 set or clear the UM, ERL and EXL flags, and these flags read back in those same positions.
- R2: A Cause write changes only bits 0x00C00300 and leaves all other bits as they were. irq_recheck is high in the same cycle as a Cause write whose data has bit 8 or bit 9 set, and low otherwise.
- R3: An EntryHi write stores the data with bits 12:8 cleared. tlb_flush is high during the write cycle only when data bits 7:0 differ from the stored bits 7:0.
- R4: An Index write stores only the data bits below log2(TLB_ENTRIES); bit 31 is not writable. Wired is masked the same way. With the default of 16 entries, both keep bits 3:0.
- R5: EBase reads bit 31 as 1, bits 29:12 as the last written value, and bits 9:0 as the fixed CPU_NUM value (default 0x3A5).
- R6: While eret is high, pc_load and ll_clear are high. If ERL is set, pc_target is ErrorEPC and ERL clears at the edge. Otherwise pc_target is EPC and EXL clears.
- R7: While di or ei is high, status_old shows the current Status value. At the edge, Status bit 0 is cleared by di and set by ei.
- R8: HWREna keeps only bits 3:0. A hardware read of number n with HWREna bit n clear raises exc_req with exc_code 10 and returns hw_data 0. With the bit set, hw_data is: 0 gives EBase & 0x2FF, 1 gives SYNCI_STEP, 2 gives count_in, 3 gives CC_RES.
- R9: fpu_op with Status CU1 (bit 29) clear raises exc_req with exc_code 11 and exc_cop 1. With CU1 set, no exception is raised.
- R10: After reset, every register reads zero except Status, which reads 0x00000004 (ERL set), and EBase, which reads 0x80000000 combined with CPU_NUM.
- R11: Selectors 9 to 31 read zero, and writes to them change no implemented register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Write selector |
| wr_data | input | 32 | Write data |
| rd_sel | input | 5 | Read selector |
| rd_data | output | 32 | Selected register value |
| eret | input | 1 | Exception return |
| di | input | 1 | Interrupt disable |
| ei | input | 1 | Interrupt enable |
| status_old | output | 32 | Status value returned by di/ei |
| pc_load | output | 1 | Redirect fetch to pc_target |
| pc_target | output | 32 | Exception return address |
| ll_clear | output | 1 | Reset load-linked state |
| tlb_flush | output | 1 | Translation cache flush request |
| irq_recheck | output | 1 | Software interrupt bits written |
| hw_rd | input | 1 | User hardware register read |
| hw_num | input | 2 | Hardware register number |
| count_in | input | 32 | Cycle counter value from the timer |
| hw_data | output | 32 | Hardware register read data |
| fpu_op | input | 1 | Floating-point operation issued |
| exc_req | output | 1 | Exception request |
| exc_code | output | 5 | Exception cause code (10 reserved instruction, 11 coprocessor unusable) |
| exc_cop | output | 2 | Coprocessor number for code 11 |

## Verification
The hardest state to reach is exception return through the EXL path. After reset ERL is set, so the first return always takes the error address. The stimulus therefore performs one return to clear ERL, then writes Status with only EXL set before a second return. That second return must take the EPC address and leave ERL clear. The flush request is also tested with a write that keeps the identifier bits but changes the upper tag, to show that a tag change alone requests no flush.

// File: rtl/cp0_regs.sv
module cp0_regs #(
  parameter int          TLB_ENTRIES = 16,
  parameter logic [9:0]  CPU_NUM     = 10'h3A5,
  parameter logic [31:0] SYNCI_STEP  = 32'd32,
  parameter logic [31:0] CC_RES      = 32'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        eret,
  input  logic        di,
  input  logic        ei,
  output logic [31:0] status_old,
  output logic        pc_load,
  output logic [31:0] pc_target,
  output logic        ll_clear,
  output logic        tlb_flush,
  output logic        irq_recheck,
  input  logic        hw_rd,
  input  logic [1:0]  hw_num,
  input  logic [31:0] count_in,
  output logic [31:0] hw_data,
  input  logic        fpu_op,
  output logic        exc_req,
  output logic [4:0]  exc_code,
  output logic [1:0]  exc_cop
);
  localparam int IW = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;
  localparam logic [4:0] S_INDEX = 5'd0, S_WIRED = 5'd1, S_HWRENA = 5'd2,
                         S_EHI = 5'd3, S_STATUS = 5'd4, S_CAUSE = 5'd5,
                         S_EPC = 5'd6, S_ERREPC = 5'd7, S_EBASE = 5'd8;
  localparam logic [31:0] STATUS_MASK = 32'hFA78FF01;
  localparam logic [31:0] CAUSE_WMASK = 32'h00C00300;
  localparam logic [4:0]  EXC_RI = 5'd10, EXC_CPU = 5'd11;

  logic [IW-1:0] index_q, wired_q;
  logic [3:0]    hwrena_q;
  logic [31:0]   ehi_q, status_q, cause_q, epc_q, errorepc_q;
  logic [17:0]   ebase_q;
  logic          um_q, erl_q, exl_q;

  logic [31:0] status_rd, ebase_rd;
  assign status_rd = status_q | {27'd0, um_q, 1'b0, erl_q, exl_q, 1'b0};
  assign ebase_rd  = {2'b10, ebase_q, 2'b00, CPU_NUM};

  logic wr_ehi, wr_cause;
  assign wr_ehi   = wr_en && (wr_sel == S_EHI);
  assign wr_cause = wr_en && (wr_sel == S_CAUSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= '0;
      wired_q    <= '0;
      hwrena_q   <= '0;
      ehi_q      <= '0;
      status_q   <= '0;
      cause_q    <= '0;
      epc_q      <= '0;
      errorepc_q <= '0;
      ebase_q    <= '0;
      um_q       <= 1'b0;
      erl_q      <= 1'b1;
      exl_q      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          S_INDEX:  index_q    <= wr_data[IW-1:0];
          S_WIRED:  wired_q    <= wr_data[IW-1:0];
          S_HWRENA: hwrena_q   <= wr_data[3:0];
          S_EHI:    ehi_q      <= wr_data & ~32'h00001F00;
          S_STATUS: begin
            status_q <= wr_data & STATUS_MASK;
            um_q     <= wr_data[4];
            erl_q    <= wr_data[2];
            exl_q    <= wr_data[1];
          end
          S_CAUSE:  cause_q    <= (cause_q & ~CAUSE_WMASK) | (wr_data & CAUSE_WMASK);
          S_EPC:    epc_q      <= wr_data;
          S_ERREPC: errorepc_q <= wr_data;
          S_EBASE:  ebase_q    <= wr_data[29:12];
          default: ;
        endcase
      end
      if (eret) begin
        if (erl_q) erl_q <= 1'b0;
        else       exl_q <= 1'b0;
      end
      if (di) status_q[0] <= 1'b0;
      if (ei) status_q[0] <= 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      S_INDEX:  rd_data = 32'(index_q);
      S_WIRED:  rd_data = 32'(wired_q);
      S_HWRENA: rd_data = {28'd0, hwrena_q};
      S_EHI:    rd_data = ehi_q;
      S_STATUS: rd_data = status_rd;
      S_CAUSE:  rd_data = cause_q;
      S_EPC:    rd_data = epc_q;
      S_ERREPC: rd_data = errorepc_q;
      S_EBASE:  rd_data = ebase_rd;
      default:  rd_data = '0;
    endcase
  end

  assign status_old  = status_rd;
  assign pc_load     = eret;
  assign ll_clear    = eret;
  assign pc_target   = erl_q ? errorepc_q : epc_q;
  assign tlb_flush   = wr_ehi && (wr_data[7:0] != ehi_q[7:0]);
  assign irq_recheck = wr_cause && (wr_data[9:8] != 2'b00);

  logic rdhwr_fault, cu_fault;
  logic [31:0] hw_val;
  assign rdhwr_fault = hw_rd && !hwrena_q[hw_num];
  assign cu_fault    = fpu_op && !status_q[29];

  always_comb begin
    case (hw_num)
      2'd0:    hw_val = ebase_rd & 32'h000002FF;
      2'd1:    hw_val = SYNCI_STEP;
      2'd2:    hw_val = count_in;
      default: hw_val = CC_RES;
    endcase
  end

  assign hw_data  = (hw_rd && !rdhwr_fault) ? hw_val : 32'd0;
  assign exc_req  = rdhwr_fault || cu_fault;
  assign exc_code = cu_fault ? EXC_CPU : (rdhwr_fault ? EXC_RI : 5'd0);
  assign exc_cop  = cu_fault ? 2'd1 : 2'd0;
endmodule

module cp0_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_sel,
  input logic        eret,
  input logic        di,
  input logic        ei,
  input logic        hw_rd,
  input logic        fpu_op,
  input logic        tlb_flush,
  input logic        exc_req,
  input logic [31:0] status_rd,
  input logic [31:0] ehi_q,
  input logic [31:0] cause_q,
  input logic        erl_q,
  input logic        exl_q
);
  a_r3_flush_changes_asid: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |=> (ehi_q[7:0] != $past(ehi_q[7:0])));
  a_r3_no_flush_keeps_asid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 5'd3 && !tlb_flush) |=> $stable(ehi_q[7:0]));
  a_r2_cause_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~32'h00C00300) == ($past(cause_q) & ~32'h00C00300)));
  a_r6_eret_erl_path: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && erl_q && !wr_en) |=> (!erl_q && exl_q == $past(exl_q)));
  a_r6_eret_exl_path: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !erl_q && !wr_en) |=> (!exl_q && !erl_q));
  a_r7_di_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (di && !ei) |=> !status_rd[0]);
  a_r7_ei_sets_ie: assert property (@(posedge clk) disable iff (!rst_n)
    ei |=> status_rd[0]);
  a_r8_exc_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (hw_rd || fpu_op));
endmodule

bind cp0_regs cp0_regs_chk u_cp0_regs_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .eret(eret), .di(di), .ei(ei), .hw_rd(hw_rd), .fpu_op(fpu_op),
  .tlb_flush(tlb_flush), .exc_req(exc_req), .status_rd(status_rd),
  .ehi_q(ehi_q), .cause_q(cause_q), .erl_q(erl_q), .exl_q(exl_q)
);

// File: tb/test_cp0_regs.sv
module test_cp0_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, eret = 0, di = 0, ei = 0, hw_rd = 0, fpu_op = 0;
  logic [4:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, count_in = 32'hCAFE0123;
  logic [1:0] hw_num = 0;
  logic [31:0] rd_data, status_old, pc_target, hw_data;
  logic pc_load, ll_clear, tlb_flush, irq_recheck, exc_req;
  logic [4:0] exc_code;
  logic [1:0] exc_cop;
  int checks = 0, errors = 0;
  logic flush_seen, recheck_seen;

  localparam logic [4:0] X_IDX = 0, X_WIR = 1, X_HWE = 2, X_EHI = 3, X_ST = 4,
                         X_CA = 5, X_EPC = 6, X_EEPC = 7, X_EB = 8;

  always #10 clk = ~clk;

  cp0_regs i_cp0_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .eret(eret), .di(di), .ei(ei),
    .status_old(status_old), .pc_load(pc_load), .pc_target(pc_target),
    .ll_clear(ll_clear), .tlb_flush(tlb_flush), .irq_recheck(irq_recheck),
    .hw_rd(hw_rd), .hw_num(hw_num), .count_in(count_in), .hw_data(hw_data),
    .fpu_op(fpu_op), .exc_req(exc_req), .exc_code(exc_code), .exc_cop(exc_cop)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    #1;
    flush_seen = tlb_flush; recheck_seen = irq_recheck;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(X_ST, v);  check("R10 status", v, 32'h4);
    rd(X_EB, v);  check("R10 ebase", v, 32'h800003A5);
    rd(X_IDX, v); check("R10 index", v, 0);
    rd(X_CA, v);  check("R10 cause", v, 0);
    rd(X_HWE, v); check("R10 hwrena", v, 0);
    rd(X_EHI, v); check("R10 entryhi", v, 0);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(X_ST, 32'hFFFFFFFF); rd(X_ST, v); check("R1 status ones", v, 32'hFA78FF17);
    wr(X_ST, 32'h0);        rd(X_ST, v); check("R1 status zero", v, 32'h0);
  endtask

  task automatic t_cause;
    logic [31:0] v;
    wr(X_CA, 32'hFFFFFFFF); rd(X_CA, v);
    check("R2 cause ones", v, 32'h00C00300);
    check("R2 recheck on sw bits", {31'd0, recheck_seen}, 1);
    wr(X_CA, 32'h00400000); rd(X_CA, v);
    check("R2 cause partial", v, 32'h00400000);
    check("R2 no recheck", {31'd0, recheck_seen}, 0);
  endtask

  task automatic t_entryhi;
    logic [31:0] v;
    wr(X_EHI, 32'h12345FAB); rd(X_EHI, v);
    check("R3 entryhi mask", v, 32'h123440AB);
    check("R3 flush on asid change", {31'd0, flush_seen}, 1);
    wr(X_EHI, 32'h999900AB); rd(X_EHI, v);
    check("R3 tag update", v, 32'h999900AB);
    check("R3 no flush same asid", {31'd0, flush_seen}, 0);
    wr(X_EHI, 32'h000000AC);
    check("R3 flush second change", {31'd0, flush_seen}, 1);
  endtask

  task automatic t_index;
    logic [31:0] v;
    wr(X_IDX, 32'hFFFFFFFF); rd(X_IDX, v); check("R4 index mask", v, 32'hF);
    wr(X_WIR, 32'hFFFFFFF5); rd(X_WIR, v); check("R4 wired mask", v, 32'h5);
  endtask

  task automatic t_ebase;
    logic [31:0] v;
    wr(X_EB, 32'hFFFFFFFF); rd(X_EB, v); check("R5 ebase ones", v, 32'hBFFFF3A5);
    wr(X_EB, 32'h0);        rd(X_EB, v); check("R5 ebase zero", v, 32'h800003A5);
  endtask

  task automatic t_eret;
    logic [31:0] v;
    wr(X_EPC, 32'h00001000);
    wr(X_EEPC, 32'h00002000);
    wr(X_ST, 32'h00000004);
    @(negedge clk); eret = 1; #1;
    check("R6 erl target", pc_target, 32'h2000);
    check("R6 pc_load", {31'd0, pc_load}, 1);
    check("R6 ll_clear", {31'd0, ll_clear}, 1);
    @(negedge clk); eret = 0;
    rd(X_ST, v); check("R6 erl cleared", v, 32'h0);
    wr(X_ST, 32'h00000002);
    @(negedge clk); eret = 1; #1;
    check("R6 exl target", pc_target, 32'h1000);
    @(negedge clk); eret = 0;
    rd(X_ST, v); check("R6 exl cleared", v, 32'h0);
  endtask

  task automatic t_diei;
    logic [31:0] v;
    wr(X_ST, 32'h00000001);
    @(negedge clk); di = 1; #1;
    check("R7 di old value", status_old, 32'h1);
    @(negedge clk); di = 0;
    rd(X_ST, v); check("R7 di clears ie", v, 32'h0);
    @(negedge clk); ei = 1; #1;
    check("R7 ei old value", status_old, 32'h0);
    @(negedge clk); ei = 0;
    rd(X_ST, v); check("R7 ei sets ie", v, 32'h1);
  endtask

  task automatic t_rdhwr;
    logic [31:0] v;
    wr(X_HWE, 32'h0);
    @(negedge clk); hw_rd = 1; hw_num = 2; #1;
    check("R8 denied exc", {31'd0, exc_req}, 1);
    check("R8 denied code", {27'd0, exc_code}, 10);
    check("R8 denied data", hw_data, 0);
    hw_rd = 0;
    wr(X_HWE, 32'hFFFFFFFF); rd(X_HWE, v); check("R8 hwrena mask", v, 32'hF);
    @(negedge clk); hw_rd = 1; hw_num = 0; #1;
    check("R8 cpu num", hw_data, 32'h2A5);
    check("R8 no exc", {31'd0, exc_req}, 0);
    hw_num = 1; #1; check("R8 synci step", hw_data, 32);
    hw_num = 2; #1; check("R8 counter", hw_data, 32'hCAFE0123);
    hw_num = 3; #1; check("R8 resolution", hw_data, 2);
    hw_rd = 0;
  endtask

  task automatic t_cu1;
    wr(X_ST, 32'h0);
    @(negedge clk); fpu_op = 1; #1;
    check("R9 cu1 exc", {31'd0, exc_req}, 1);
    check("R9 cu1 code", {27'd0, exc_code}, 11);
    check("R9 cu1 cop", {30'd0, exc_cop}, 1);
    fpu_op = 0;
    wr(X_ST, 32'h20000000);
    @(negedge clk); fpu_op = 1; #1;
    check("R9 cu1 allowed", {31'd0, exc_req}, 0);
    fpu_op = 0;
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    wr(5'd20, 32'hFFFFFFFF); rd(5'd20, v); check("R11 unimpl read", v, 0);
    wr(5'd9, 32'hFFFFFFFF);
    rd(X_IDX, v); check("R11 index untouched", v, 32'hF);
    rd(X_CA, v);  check("R11 cause untouched", v, 32'h00400000);
    rd(X_ST, v);  check("R11 status untouched", v, 32'h20000000);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_status;
    t_cause;
    t_entryhi;
    t_index;
    t_ebase;
    t_eret;
    t_diei;
    t_rdhwr;
    t_cu1;
    t_unimpl;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule